// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block drives the control strobes of a classic 8-bit controller bus on which the low address byte and the data share one set of pins. It runs on the oscillator clock. A machine cycle lasts twelve clocks, split into six states of two phases each. The first three states form slot A and the last three form slot B. Each slot carries one of four activities. An internal slot drives no bus. A code-fetch slot emits an address and then a program-store read strobe. A data-address slot emits the data address. A data-strobe slot pulses the read or write strobe.

At every machine-cycle boundary the core presents three things: whether code executes from external memory, an optional data access (read or write), and whether that access uses a 16-bit address. A data access takes two machine cycles. In the first cycle the data address replaces the second code fetch. In the second cycle the read or write strobe replaces the first address strobe and the first code fetch. As a result one address-latch pulse is skipped and two program-store strobes are dropped. The address-latch strobe otherwise runs freely at one sixth of the clock rate. A control bit can limit it to slots that carry a real external address. That bit is written through a small register-write port at a fixed register address.

Top module: `bus_strobe_seq`

## Requirements
- R1: While reset is high, and in the clock that follows it, every output is 0. The ALE-disable bit resets to 0. The first machine cycle's inputs are sampled at the first clock edge after reset is released.
- R2: A machine cycle is 12 clocks, at positions 0 to 11. With ALE enabled, `ale` is high for exactly one clock at positions 1 and 7, except where R5 skips it. It is never high in two consecutive clocks.
- R3: In a code-fetch slot, `psen` is high at positions 2-5 (slot A) or 8-11 (slot B). When `code_ext` was 0 at the cycle's boundary, `psen` stays 0 for the whole cycle.
- R4: In a code-fetch or data-address slot, `lo_addr_oe` is high at the slot's first two positions (0-1 or 6-7), so the address is out before ALE falls. It is never high together with `data_oe`.
- R5: A data access runs over two machine cycles. In the first cycle, slot B is a data-address slot: `ale` is at position 7, `lo_addr_oe` at 6-7, and there is no `psen`. In the second cycle, slot A is a data-strobe slot: there is no `ale` at position 1, no `psen`, and the strobe is high at positions 0-5. The second cycle's slot B follows `code_ext`. `ale` and `psen` never coincide with a strobe.
- R6: `acc_op` is encoded as follows: bit 1 requests an access, and bit 0 selects a write (1) or a read (0). The values 2'b00 and 2'b01 request nothing. A read raises `rd_stb` only. A write raises `wr_stb` and `data_oe` over the same positions. `rd_stb` and `wr_stb` are never high together.
- R7: `hi_addr_sel` (1 = high address byte, 0 = the port's own latch) is 1 throughout code-fetch slots. It is 0 throughout internal slots. Throughout data-address and data-strobe slots it equals the `acc_wide` value that was sampled with the request.
- R8: A write with `cfg_addr` = 8'hAF sets the ALE-disable bit to `cfg_wdata[0]`. While the bit is 1, internal slots carry no `ale`, but code-fetch and data-address slots still pulse it. Writes to any other address have no effect.
- R9: `code_ext`, `acc_op` and `acc_wide` are sampled only at the edge that starts a machine cycle, so changes inside a cycle have no effect. A request presented at the start of a data access's second cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| code_ext | input | 1 | Code is fetched from external memory |
| acc_op | input | 2 | Data access request (bit 1 = access, bit 0 = write) |
| acc_wide | input | 1 | Data access uses a 16-bit address |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| ale | output | 1 | Address-latch strobe |
| psen | output | 1 | Program-store read strobe (active high) |
| rd_stb | output | 1 | Data read strobe (active high) |
| wr_stb | output | 1 | Data write strobe (active high) |
| lo_addr_oe | output | 1 | Drive low address byte onto the shared bus |
| data_oe | output | 1 | Drive write data onto the shared bus |
| hi_addr_sel | output | 1 | High-address pins source: 1 address byte, 0 port latch |

## Verification
Two features can land on the same boundary edge: a register write that disables ALE and a new data request. The bench provokes this by issuing both together. It then checks that the data-address slot still pulses ALE while the surrounding internal slots go quiet, and that the following cycle still skips the pulse and raises the strobe. The bench also presents a fresh write request at the start of the second data cycle, and scrambles every request input just after a boundary. The expected pattern is built only from the values sampled at the boundaries.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [1:0] {
    SL_INT   = 2'd0,
    SL_FETCH = 2'd1,
    SL_DADDR = 2'd2,
    SL_DSTB  = 2'd3
  } slot_e;
endpackage

// File: rtl/mc_timer.sv
module mc_timer #(
  parameter int MC_LEN = 12,
  localparam int PW = $clog2(MC_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] pos_q,
  output logic [PW-1:0] pos_nxt,
  output logic          wrap
);
  localparam logic [PW-1:0] LAST = PW'(MC_LEN - 1);

  assign wrap    = (pos_q == LAST);
  assign pos_nxt = wrap ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) pos_q <= LAST;
    else     pos_q <= pos_nxt;
  end

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (rst) pos_q <= LAST);
endmodule

// File: rtl/mc_planner.sv
module mc_planner
  import bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrap,
  input  logic       code_ext,
  input  logic [1:0] acc_op,
  input  logic       acc_wide,
  output slot_e      slot_a_nxt,
  output slot_e      slot_b_nxt,
  output logic       wr_nxt,
  output logic       wide_nxt
);
  slot_e slot_a_q, slot_b_q;
  logic  pend_q, pend_nxt, wr_q, wide_q;
  slot_e code_kind;

  assign code_kind = code_ext ? SL_FETCH : SL_INT;

  always_comb begin
    slot_a_nxt = slot_a_q;
    slot_b_nxt = slot_b_q;
    pend_nxt   = pend_q;
    wr_nxt     = wr_q;
    wide_nxt   = wide_q;
    if (wrap) begin
      if (pend_q) begin
        slot_a_nxt = SL_DSTB;
        slot_b_nxt = code_kind;
        pend_nxt   = 1'b0;
      end else if (acc_op[1]) begin
        slot_a_nxt = code_kind;
        slot_b_nxt = SL_DADDR;
        pend_nxt   = 1'b1;
        wr_nxt     = acc_op[0];
        wide_nxt   = acc_wide;
      end else begin
        slot_a_nxt = code_kind;
        slot_b_nxt = code_kind;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_a_q <= SL_INT;
      slot_b_q <= SL_INT;
      pend_q   <= 1'b0;
      wr_q     <= 1'b0;
      wide_q   <= 1'b0;
    end else begin
      slot_a_q <= slot_a_nxt;
      slot_b_q <= slot_b_nxt;
      pend_q   <= pend_nxt;
      wr_q     <= wr_nxt;
      wide_q   <= wide_nxt;
    end
  end

  // R5
  pend_follows_addr_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> (slot_b_q == SL_DADDR));
  // R5
  no_double_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && wrap) |=> !pend_q);
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import bus_seq_pkg::*;
#(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  localparam int MC_LEN = STATES * PHASES,
  localparam int HALF   = MC_LEN / 2,
  localparam int PW     = $clog2(MC_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pos_nxt,
  input  slot_e         slot_a,
  input  slot_e         slot_b,
  input  logic          wr,
  input  logic          wide,
  input  logic          ale_off,
  output logic          ale_q,
  output logic          psen_q,
  output logic          rd_q,
  output logic          wr_q,
  output logic          lo_oe_q,
  output logic          data_oe_q,
  output logic          hi_sel_q
);
  localparam logic [PW-1:0] HALF_P  = PW'(HALF);
  localparam logic [PW-1:0] PHASE_P = PW'(PHASES);
  localparam logic [PW-1:0] PH_LAST = PW'(PHASES - 1);

  slot_e         cur;
  logic [PW-1:0] loc, st_in_slot, ph;
  logic          first_st, ale_d, psen_d, rd_d, wr_d, lo_d, doe_d, hi_d;

  always_comb begin
    cur        = (pos_nxt < HALF_P) ? slot_a : slot_b;
    loc        = (pos_nxt < HALF_P) ? pos_nxt : pos_nxt - HALF_P;
    st_in_slot = loc / PHASE_P;
    ph         = loc % PHASE_P;
    first_st   = (st_in_slot == '0);
    ale_d  = first_st && (ph == PH_LAST) &&
             ((cur == SL_FETCH) || (cur == SL_DADDR) || ((cur == SL_INT) && !ale_off));
    psen_d = (cur == SL_FETCH) && !first_st;
    rd_d   = (cur == SL_DSTB) && !wr;
    wr_d   = (cur == SL_DSTB) && wr;
    doe_d  = (cur == SL_DSTB) && wr;
    lo_d   = first_st && ((cur == SL_FETCH) || (cur == SL_DADDR));
    case (cur)
      SL_FETCH: hi_d = 1'b1;
      SL_DADDR,
      SL_DSTB:  hi_d = wide;
      default:  hi_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q     <= 1'b0;
      psen_q    <= 1'b0;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      lo_oe_q   <= 1'b0;
      data_oe_q <= 1'b0;
      hi_sel_q  <= 1'b0;
    end else begin
      ale_q     <= ale_d;
      psen_q    <= psen_d;
      rd_q      <= rd_d;
      wr_q      <= wr_d;
      lo_oe_q   <= lo_d;
      data_oe_q <= doe_d;
      hi_sel_q  <= hi_d;
    end
  end

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (rst) ale_q |=> !ale_q);
  // R5
  psen_vs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(psen_q && (rd_q || wr_q)));
  // R5
  ale_vs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(ale_q && (rd_q || wr_q)));
  // R4
  bus_owner_chk: assert property (@(posedge clk) disable iff (rst) !(lo_oe_q && data_oe_q));
  // R6
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst) !(rd_q && wr_q));
endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
  import bus_seq_pkg::*;
#(
  parameter int           STATES      = 6,
  parameter int           PHASES      = 2,
  parameter int           CFG_AW      = 8,
  parameter int           CFG_DW      = 8,
  parameter logic [7:0]   CTL_ADDR    = 8'hAF,
  parameter int           ALE_OFF_BIT = 0,
  localparam int          MC_LEN      = STATES * PHASES,
  localparam int          PW          = $clog2(MC_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              code_ext,
  input  logic [1:0]        acc_op,
  input  logic              acc_wide,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic              ale,
  output logic              psen,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              lo_addr_oe,
  output logic              data_oe,
  output logic              hi_addr_sel
);
  localparam logic [CFG_AW-1:0] CTL_A = CFG_AW'(CTL_ADDR);

  logic [PW-1:0] pos_q, pos_nxt;
  logic          wrap, wr_nxt, wide_nxt, ale_off_q;
  slot_e         slot_a_nxt, slot_b_nxt;

  always_ff @(posedge clk) begin
    if (rst)                             ale_off_q <= 1'b0;
    else if (cfg_we && cfg_addr == CTL_A) ale_off_q <= cfg_wdata[ALE_OFF_BIT];
  end

  mc_timer #(.MC_LEN(MC_LEN)) u_timer (
    .clk(clk), .rst(rst), .pos_q(pos_q), .pos_nxt(pos_nxt), .wrap(wrap)
  );

  mc_planner u_plan (
    .clk(clk), .rst(rst), .wrap(wrap), .code_ext(code_ext), .acc_op(acc_op),
    .acc_wide(acc_wide), .slot_a_nxt(slot_a_nxt), .slot_b_nxt(slot_b_nxt),
    .wr_nxt(wr_nxt), .wide_nxt(wide_nxt)
  );

  strobe_decode #(.STATES(STATES), .PHASES(PHASES)) u_dec (
    .clk(clk), .rst(rst), .pos_nxt(pos_nxt), .slot_a(slot_a_nxt), .slot_b(slot_b_nxt),
    .wr(wr_nxt), .wide(wide_nxt), .ale_off(ale_off_q),
    .ale_q(ale), .psen_q(psen), .rd_q(rd_stb), .wr_q(wr_stb),
    .lo_oe_q(lo_addr_oe), .data_oe_q(data_oe), .hi_sel_q(hi_addr_sel)
  );

  // R3
  psen_needs_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (psen && !$past(psen)) |-> $past(lo_addr_oe, 2));
endmodule

// File: tb/bus_strobe_seq_tb.sv
module bus_strobe_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       code_ext = 1'b0;
  logic [1:0] acc_op = 2'b00;
  logic       acc_wide = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic [7:0] cfg_wdata = 8'h00;
  logic ale, psen, rd_stb, wr_stb, lo_addr_oe, data_oe, hi_addr_sel;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit b_pend = 0, b_wr = 0, b_wide = 0, b_aoff = 0;

  always #4 clk = ~clk;

  bus_strobe_seq u_dut (
    .clk(clk), .rst(rst), .code_ext(code_ext), .acc_op(acc_op), .acc_wide(acc_wide),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ale(ale), .psen(psen), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .lo_addr_oe(lo_addr_oe), .data_oe(data_oe), .hi_addr_sel(hi_addr_sel)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      $display("FAIL watchdog: run hung (actual cycles %0d, expected < 20000)", cyc);
      errors = errors + 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // slot codes: 0 internal, 1 code fetch, 2 data address, 3 data strobe
  function automatic logic [6:0] expv(int p, int slot, bit w, bit wd, bit aoff);
    int loc = p % 6;
    int k = loc / 2;
    bit ph = (loc % 2) == 1;
    logic a, ps, r, wv, lo, doe, hi;
    a   = (k == 0) && ph && (slot == 1 || slot == 2 || (slot == 0 && !aoff));
    ps  = (slot == 1) && (k > 0);
    r   = (slot == 3) && !w;
    wv  = (slot == 3) && w;
    doe = (slot == 3) && w;
    lo  = (k == 0) && (slot == 1 || slot == 2);
    hi  = (slot == 1) ? 1'b1 : ((slot >= 2) ? wd : 1'b0);
    return {a, ps, r, wv, lo, doe, hi};
  endfunction

  task automatic check(string tag, logic [6:0] act, logic [6:0] exp, int p);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s pos %0d: actual %b expected %b (ale,psen,rd,wr,lo_oe,d_oe,hi_sel)",
               tag, p, act, exp);
    end
  endtask

  // one machine cycle; entered and left at the negedge before a cycle boundary
  task automatic mcycle(string tag, bit ce, logic [1:0] op, bit wd, bit scramble,
                        bit cfg, logic [7:0] caddr, logic [7:0] cdata);
    int sa, sb;
    bit w, wide_c;
    code_ext = ce; acc_op = op; acc_wide = wd;
    cfg_we = cfg; cfg_addr = caddr; cfg_wdata = cdata;
    if (cfg && caddr == 8'hAF) b_aoff = cdata[0];
    if (b_pend) begin
      sa = 3; sb = ce ? 1 : 0; w = b_wr; wide_c = b_wide; b_pend = 0;
    end else if (op[1]) begin
      sa = ce ? 1 : 0; sb = 2; b_pend = 1; b_wr = op[0]; b_wide = wd;
      w = op[0]; wide_c = wd;
    end else begin
      sa = ce ? 1 : 0; sb = sa; w = 0; wide_c = 0;
    end
    for (int p = 0; p < 12; p++) begin
      @(posedge clk);
      @(negedge clk);
      check(tag, {ale, psen, rd_stb, wr_stb, lo_addr_oe, data_oe, hi_addr_sel},
            expv(p, (p < 6) ? sa : sb, w, wide_c, b_aoff), p);
      if (p == 0) begin
        cfg_we = 1'b0;
        if (scramble) begin
          code_ext = ~ce; acc_op = 2'b11; acc_wide = ~wd;
        end
      end
    end
    code_ext = 1'b0; acc_op = 2'b00; acc_wide = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {ale, psen, rd_stb, wr_stb, lo_addr_oe, data_oe, hi_addr_sel}, 7'b0, 0);
    rst = 1'b0;
  endtask

  task automatic t_internal();
    mcycle("R1 R2 internal", 0, 2'b00, 0, 0, 0, 8'h00, 8'h00);
    mcycle("R2 R6 op01 none", 0, 2'b01, 1, 0, 0, 8'h00, 8'h00);
  endtask

  task automatic t_fetch();
    mcycle("R3 R4 R7 fetch", 1, 2'b00, 0, 0, 0, 8'h00, 8'h00);
    mcycle("R3 no psen internal", 0, 2'b00, 0, 0, 0, 8'h00, 8'h00);
  endtask

  task automatic t_data_read();
    mcycle("R5 R6 read c1", 1, 2'b10, 0, 0, 0, 8'h00, 8'h00);
    mcycle("R5 R7 read c2", 1, 2'b00, 0, 0, 0, 8'h00, 8'h00);
  endtask

  task automatic t_data_write();
    mcycle("R5 R6 R7 write c1", 0, 2'b11, 1, 0, 0, 8'h00, 8'h00);
    mcycle("R6 R9 write c2 req ignored", 1, 2'b11, 0, 0, 0, 8'h00, 8'h00);
    mcycle("R9 after ignored req", 1, 2'b00, 0, 0, 0, 8'h00, 8'h00);
  endtask

  task automatic t_ale_off();
    mcycle("R8 disable + data req", 0, 2'b10, 1, 0, 1, 8'hAF, 8'h01);
    mcycle("R8 strobe cycle quiet", 0, 2'b00, 0, 0, 0, 8'h00, 8'h00);
    mcycle("R8 fetch keeps ale", 1, 2'b00, 0, 0, 0, 8'h00, 8'h00);
    mcycle("R8 re-enable", 0, 2'b00, 0, 0, 1, 8'hAF, 8'hFE);
    mcycle("R8 other address", 0, 2'b00, 0, 0, 1, 8'hAE, 8'h01);
    mcycle("R8 other address after", 0, 2'b00, 0, 0, 0, 8'h00, 8'h00);
  endtask

  task automatic t_midcycle();
    mcycle("R9 scrambled internal", 0, 2'b00, 0, 1, 0, 8'h00, 8'h00);
    mcycle("R9 scrambled fetch", 1, 2'b00, 1, 1, 0, 8'h00, 8'h00);
    mcycle("R9 scrambled read c1", 1, 2'b10, 1, 1, 0, 8'h00, 8'h00);
    mcycle("R9 scrambled read c2", 0, 2'b00, 0, 1, 0, 8'h00, 8'h00);
  endtask

  initial begin
    t_reset();
    t_internal();
    t_fetch();
    t_data_read();
    t_data_write();
    t_ale_off();
    t_midcycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule